// File: doc/BRIEF.md
# IDE Cycle Strobe Timing Generator

This block produces the read and write strobes for one IDE channel that carries two drives. A cycle request names the target drive, the direction, whether the cycle is a PIO or a DMA transfer, and whether it targets the data port. The block drives the active-low read or write strobe for that cycle. It samples the drive's IORDY line at a programmable point. It then enforces a recovery gap before the next strobe may start. All times are counted in clock cycles.

The timing comes from a 16-bit configuration word and a 4-bit slave timing word. Each drive has three enable bits: fast timing, DMA-only fast timing and IORDY sampling. These decide whether a cycle uses the slow compatible timing or a fast sample-point and recovery pair. When the separate-drive-1 bit is set, drive 1 takes its fast pair from the slave word. The timing, the IORDY enable and the direction are captured when a request is accepted. A change to the configuration therefore never affects a cycle that is already running.

A request is accepted in a cycle where `req_valid` and `req_ready` are both high. The strobe asserts in the following cycle. `done` pulses for one cycle, and that cycle is the first cycle with the strobe deasserted.

Top module: `ide_strobe_gen`

## Requirements
- R1: After reset both strobes are high (deasserted) and `done` is low. `req_ready` is high exactly when the decode enable `cfg_word[15]` is 1.
- R2: While `cfg_word[15]` is 0, `req_ready` stays low and no strobe asserts, whatever `req_valid` does.
- R3: For a fast-timed cycle, the strobe stays low for exactly the number of cycles given by the sample-point code when IORDY sampling is off. The code is `cfg_word[13:12]`, or `slave_word[3:2]` for drive 1 when the separate bit is set. The codes map as follows: 00 gives 5, 01 gives 4, 10 gives 3, and 11 gives 3.
- R4: Back-to-back requests on a fast-timed cycle leave the strobe high for exactly the number of cycles given by the recovery code. The code is `cfg_word[9:8]`, or `slave_word[1:0]` for drive 1 when the separate bit is set. The codes map as follows: 00 gives 4, 01 gives 3, 10 gives 2, and 11 gives 1.
- R5: A cycle uses compatible timing in two cases: when the drive's fast bit is 0 (drive 0 `cfg_word[0]`, drive 1 `cfg_word[4]`), or when the cycle is a PIO access that does not target the data port. Compatible timing means a low time of `COMPAT_SP` (12) and a back-to-back gap of `COMPAT_RC` (10).
- R6: With `cfg_word[14]` = 0, both drives use the shared fast fields. With it set to 1, drive 0 uses the shared fields and drive 1 uses `slave_word`.
- R7: When a drive's DMA-only bit is 1 (drive 0 `cfg_word[3]`, drive 1 `cfg_word[7]`), its PIO data-port cycles use compatible timing. Its DMA cycles, with or without the data-port flag, still use fast timing.
- R8: When a drive's IORDY enable is 1 (drive 0 `cfg_word[1]`, drive 1 `cfg_word[5]`), IORDY is sampled at the sample point and then on every following clock. The strobe deasserts in the cycle after IORDY is first sampled high, so each low sample adds one cycle to the low time.
- R9: When a drive's IORDY enable is 0, the level of `iordy` has no effect and the strobe ends at the sample point.
- R10: A read asserts only `dior_n` and a write asserts only `diow_n`. `done` is high for one cycle, which is the first cycle after the strobe deasserts.
- R11: The timing, the IORDY enable and the direction are taken when a request is accepted. Configuration changes made during a cycle affect only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all counts are in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 16 | Channel timing configuration word |
| slave_word | input | 4 | Drive 1 fast fields: [3:2] sample-point code, [1:0] recovery code |
| req_valid | input | 1 | Cycle request present |
| req_drive | input | 1 | Target drive (0 or 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dma | input | 1 | 1 = DMA transfer, 0 = PIO |
| req_dataport | input | 1 | 1 = PIO access to the data port |
| iordy | input | 1 | Drive ready line, high = ready |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| dior_n | output | 1 | Active-low read strobe |
| diow_n | output | 1 | Active-low write strobe |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check four rules on every cycle:
- the two strobes are never low together;
- a strobe only starts in the cycle after an accepted request;
- no request is accepted while decode is disabled;
- `done` appears only on the first high cycle after a strobe that lasted at least the shortest legal sample time.

The exact low and recovery lengths for every code depend on how the configuration bits were decoded. The same holds for the compatible-versus-fast choice under each drive bit, for the length of an IORDY stretch, and for the capture of the configuration at acceptance. Only the bench's sweeps and directed pairs of back-to-back cycles can show these.

// File: rtl/ide_strobe_pkg.sv
package ide_strobe_pkg;

    typedef struct packed {
        logic dma_only;
        logic iordy_en;
        logic fast;
    } drive_bits_t;

    typedef struct packed {
        logic [1:0] sp_code;
        logic [1:0] rc_code;
    } fast_fields_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STROBE  = 2'd1,
        ST_RECOVER = 2'd2
    } seq_state_t;

endpackage

// File: rtl/ide_drive_bits.sv
module ide_drive_bits
    import ide_strobe_pkg::*;
#(
    parameter int BASE = 0
) (
    input  logic [15:0] cfg_word,
    output drive_bits_t bits
);
    always_comb begin
        bits.fast     = cfg_word[BASE + 0];
        bits.iordy_en = cfg_word[BASE + 1];
        bits.dma_only = cfg_word[BASE + 3];
    end
endmodule

// File: rtl/ide_timing_select.sv
module ide_timing_select
    import ide_strobe_pkg::*;
#(
    parameter int COMPAT_SP = 12,
    parameter int COMPAT_RC = 10,
    parameter int CNT_W     = 4
) (
    input  drive_bits_t        drv0,
    input  drive_bits_t        drv1,
    input  fast_fields_t       shared_f,
    input  fast_fields_t       slave_f,
    input  logic               split_en,
    input  logic               req_drive,
    input  logic               req_dma,
    input  logic               req_dataport,
    output logic [CNT_W-1:0]   sp_len,
    output logic [CNT_W-1:0]   rc_len,
    output logic               iordy_en
);
    localparam logic [CNT_W-1:0] COMPAT_SP_L = CNT_W'(COMPAT_SP);
    localparam logic [CNT_W-1:0] COMPAT_RC_L = CNT_W'(COMPAT_RC);

    drive_bits_t  sel_bits;
    fast_fields_t sel_f;
    logic         use_fast;

    function automatic logic [CNT_W-1:0] sp_decode(input logic [1:0] code);
        logic [CNT_W-1:0] r;
        case (code)
            2'b00:   r = CNT_W'(5);
            2'b01:   r = CNT_W'(4);
            default: r = CNT_W'(3);
        endcase
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] rc_decode(input logic [1:0] code);
        return CNT_W'(3'd4 - {1'b0, code});
    endfunction

    always_comb begin
        sel_bits = req_drive ? drv1 : drv0;
        sel_f    = (split_en && req_drive) ? slave_f : shared_f;
        use_fast = sel_bits.fast && (req_dma || (req_dataport && !sel_bits.dma_only));
        iordy_en = sel_bits.iordy_en;
        if (use_fast) begin
            sp_len = sp_decode(sel_f.sp_code);
            rc_len = rc_decode(sel_f.rc_code);
        end else begin
            sp_len = COMPAT_SP_L;
            rc_len = COMPAT_RC_L;
        end
    end
endmodule

// File: rtl/ide_strobe_seq.sv
module ide_strobe_seq
    import ide_strobe_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             decode_en,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [CNT_W-1:0] sp_len,
    input  logic [CNT_W-1:0] rc_len,
    input  logic             iordy_en,
    input  logic             iordy,
    output logic             req_ready,
    output logic             dior_n,
    output logic             diow_n,
    output logic             done
);
    typedef struct packed {
        seq_state_t       state;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rec;
        logic             ie;
        logic             dior_n;
        logic             diow_n;
        logic             done;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (decode_en && req_valid) begin
                    r_d.state  = ST_STROBE;
                    r_d.cnt    = sp_len - CNT_W'(1);
                    r_d.rec    = rc_len;
                    r_d.ie     = iordy_en;
                    r_d.dior_n = req_write;
                    r_d.diow_n = !req_write;
                end
            end
            ST_STROBE: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end else if (!r_q.ie || iordy) begin
                    r_d.dior_n = 1'b1;
                    r_d.diow_n = 1'b1;
                    r_d.done   = 1'b1;
                    if (r_q.rec <= CNT_W'(1)) begin
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.state = ST_RECOVER;
                        r_d.cnt   = r_q.rec - CNT_W'(2);
                    end
                end
            end
            ST_RECOVER: begin
                if (r_q.cnt == '0) r_d.state = ST_IDLE;
                else               r_d.cnt   = r_q.cnt - CNT_W'(1);
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= ST_IDLE;
            r_q.cnt    <= '0;
            r_q.rec    <= '0;
            r_q.ie     <= 1'b0;
            r_q.dior_n <= 1'b1;
            r_q.diow_n <= 1'b1;
            r_q.done   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.state == ST_IDLE) && decode_en;
    assign dior_n    = r_q.dior_n;
    assign diow_n    = r_q.diow_n;
    assign done      = r_q.done;
endmodule

// File: rtl/ide_strobe_gen.sv
module ide_strobe_gen
    import ide_strobe_pkg::*;
#(
    parameter int COMPAT_SP = 12,
    parameter int COMPAT_RC = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] cfg_word,
    input  logic [3:0]  slave_word,
    input  logic        req_valid,
    input  logic        req_drive,
    input  logic        req_write,
    input  logic        req_dma,
    input  logic        req_dataport,
    input  logic        iordy,
    output logic        req_ready,
    output logic        dior_n,
    output logic        diow_n,
    output logic        done
);
    localparam int N_DRIVES = 2;
    localparam int MAX_LEN  = (COMPAT_SP > COMPAT_RC) ?
                              ((COMPAT_SP > 5) ? COMPAT_SP : 5) :
                              ((COMPAT_RC > 5) ? COMPAT_RC : 5);
    localparam int CNT_W    = $clog2(MAX_LEN + 1);

    drive_bits_t  drv [N_DRIVES];
    fast_fields_t shared_f, slave_f;
    logic [CNT_W-1:0] sp_len, rc_len;
    logic             sel_ie;

    for (genvar g = 0; g < N_DRIVES; g++) begin : g_drive
        ide_drive_bits #(.BASE(4 * g)) u_bits (
            .cfg_word (cfg_word),
            .bits     (drv[g])
        );
    end

    assign shared_f = '{sp_code: cfg_word[13:12], rc_code: cfg_word[9:8]};
    assign slave_f  = '{sp_code: slave_word[3:2], rc_code: slave_word[1:0]};

    ide_timing_select #(
        .COMPAT_SP (COMPAT_SP),
        .COMPAT_RC (COMPAT_RC),
        .CNT_W     (CNT_W)
    ) u_sel (
        .drv0         (drv[0]),
        .drv1         (drv[1]),
        .shared_f     (shared_f),
        .slave_f      (slave_f),
        .split_en     (cfg_word[14]),
        .req_drive    (req_drive),
        .req_dma      (req_dma),
        .req_dataport (req_dataport),
        .sp_len       (sp_len),
        .rc_len       (rc_len),
        .iordy_en     (sel_ie)
    );

    ide_strobe_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .decode_en (cfg_word[15]),
        .req_valid (req_valid),
        .req_write (req_write),
        .sp_len    (sp_len),
        .rc_len    (rc_len),
        .iordy_en  (sel_ie),
        .iordy     (iordy),
        .req_ready (req_ready),
        .dior_n    (dior_n),
        .diow_n    (diow_n),
        .done      (done)
    );
endmodule

// File: rtl/ide_strobe_chk.sv
module ide_strobe_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cfg_word,
    input logic        req_valid,
    input logic        req_ready,
    input logic        dior_n,
    input logic        diow_n,
    input logic        done
);
    logic       strobe_low;
    logic [7:0] low_run;

    assign strobe_low = !dior_n || !diow_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          low_run <= '0;
        else if (strobe_low) low_run <= (low_run == 8'hFF) ? low_run : low_run + 8'd1;
        else                 low_run <= '0;
    end

    // R10: a single strobe direction at a time
    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dior_n && !diow_n));

    // R2: no acceptance while decode is off
    a_r2_no_ready_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_word[15] |-> !req_ready);

    // R11: a strobe starts only after an accepted request
    a_r11_start_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_low ? 1'b0 : 1'b1) |-> $past(req_ready && req_valid));

    // R10: done is on the first high cycle after a strobe
    a_r10_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!strobe_low && $past(strobe_low)));

    // R3: every strobe lasts at least the shortest sample time
    a_r3_min_low_time: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (low_run >= 8'd3));
endmodule

bind ide_strobe_gen ide_strobe_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_word  (cfg_word),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .dior_n    (dior_n),
    .diow_n    (diow_n),
    .done      (done)
);

// File: tb/ide_strobe_gen_tb.sv
module ide_strobe_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_word = '0;
    logic [3:0]  slave_word = '0;
    logic        req_valid = 1'b0, req_drive = 1'b0, req_write = 1'b0;
    logic        req_dma = 1'b0, req_dataport = 1'b0, iordy = 1'b0;
    logic        req_ready, dior_n, diow_n, done;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ide_strobe_gen dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .slave_word(slave_word),
        .req_valid(req_valid), .req_drive(req_drive), .req_write(req_write),
        .req_dma(req_dma), .req_dataport(req_dataport), .iordy(iordy),
        .req_ready(req_ready), .dior_n(dior_n), .diow_n(diow_n), .done(done)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, act %0d cycles exp < %0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    function automatic logic strobe_low();
        return !dior_n || !diow_n;
    endfunction

    function automatic logic [15:0] mk_cfg(input logic en, input logic split,
                                           input logic [1:0] sp, input logic [1:0] rc,
                                           input logic [2:0] d1, input logic [2:0] d0);
        // d = {dma_only, iordy_en, fast}
        logic [15:0] c;
        c = '0;
        c[15] = en; c[14] = split; c[13:12] = sp; c[9:8] = rc;
        c[7] = d1[2]; c[5] = d1[1]; c[4] = d1[0];
        c[3] = d0[2]; c[1] = d0[1]; c[0] = d0[0];
        return c;
    endfunction

    function automatic int sp_exp(input int code);
        return (code == 3) ? 3 : 5 - code;
    endfunction

    function automatic int rc_exp(input int code);
        return 4 - code;
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: act %0d exp %0d", req, what, act, exp);
        end
    endtask

    // measure one strobe; iordy goes high once the low count reaches thr
    task automatic measure_low(input int thr, input logic wr, input string req,
                               input int exp_low, input logic drop_valid);
        int n = 0;
        int w = 0;
        while (!strobe_low() && w < 60) begin
            @(negedge clk);
            w++;
        end
        chk(strobe_low(), req, "strobe started", int'(strobe_low()), 1);
        chk(dior_n == wr && diow_n == !wr, req, "R10 strobe side (dior_n)",
            int'(dior_n), int'(wr));
        if (drop_valid) req_valid = 1'b0;
        while (strobe_low() && n < 80) begin
            n++;
            iordy = (n >= thr);
            @(negedge clk);
        end
        iordy = 1'b0;
        chk(n == exp_low, req, "strobe low cycles", n, exp_low);
        chk(done == 1'b1, req, "R10 done on first high cycle", int'(done), 1);
    endtask

    task automatic pair(input logic [15:0] c1, input logic [3:0] s1,
                        input logic [15:0] c2, input logic [3:0] s2,
                        input logic drv, input logic wr, input logic dma, input logic dp,
                        input int thr1, input int thr2,
                        input int el1, input int eg, input int el2, input string req);
        int g = 0;
        @(negedge clk);
        cfg_word = c1; slave_word = s1;
        req_drive = drv; req_write = wr; req_dma = dma; req_dataport = dp;
        req_valid = 1'b1;
        @(negedge clk);
        cfg_word = c2; slave_word = s2;
        measure_low(thr1, wr, req, el1, 1'b0);
        g = 1;
        @(negedge clk);
        chk(done == 1'b0, req, "R10 done lasts one cycle", int'(done), 0);
        while (!strobe_low() && g < 60) begin
            g++;
            @(negedge clk);
        end
        chk(g == eg, req, "recovery gap cycles", g, eg);
        measure_low(thr2, wr, req, el2, 1'b1);
        repeat (14) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(dior_n && diow_n, "R1", "strobes high in reset", int'(dior_n & diow_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dior_n && diow_n && !done, "R1", "idle outputs after reset",
            int'({dior_n, diow_n, done}), 6);
        chk(req_ready == 1'b0, "R1", "ready low with decode off", int'(req_ready), 0);
        cfg_word = mk_cfg(1, 0, 0, 0, 3'b000, 3'b000);
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready high with decode on", int'(req_ready), 1);

        // R2: decode disabled
        begin
            int lows = 0;
            cfg_word = mk_cfg(0, 0, 0, 0, 3'b000, 3'b001);
            req_valid = 1'b1; req_dataport = 1'b1;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (strobe_low() || req_ready) lows++;
            end
            req_valid = 1'b0;
            chk(lows == 0, "R2", "no strobe or ready while disabled", lows, 0);
        end

        // R3 R4 R10: sweep of fast fields, drive 0, IORDY off held low (R9)
        for (int sp = 0; sp < 4; sp++) begin
            for (int rc = 0; rc < 4; rc++) begin
                logic [15:0] c;
                c = mk_cfg(1, 0, 2'(sp), 2'(rc), 3'b000, 3'b001);
                pair(c, 4'h0, c, 4'h0, 1'b0, 1'((sp + rc) & 1), 1'b0, 1'b1,
                     99, 99, sp_exp(sp), rc_exp(rc), sp_exp(sp), "R3 R4 R9");
            end
        end

        // R5: fast bit clear, and non-data-port PIO with fast set
        pair(mk_cfg(1, 0, 2, 3, 3'b000, 3'b000), 4'h0, mk_cfg(1, 0, 2, 3, 3'b000, 3'b000), 4'h0,
             1'b0, 1'b0, 1'b0, 1'b1, 99, 99, 12, 10, 12, "R5 fast clear");
        pair(mk_cfg(1, 0, 2, 3, 3'b000, 3'b001), 4'h0, mk_cfg(1, 0, 2, 3, 3'b000, 3'b001), 4'h0,
             1'b0, 1'b1, 1'b0, 1'b0, 99, 99, 12, 10, 12, "R5 non-data-port");

        // R6: drive timing bank selection
        pair(mk_cfg(1, 0, 0, 0, 3'b001, 3'b000), 4'b1011, mk_cfg(1, 0, 0, 0, 3'b001, 3'b000), 4'b1011,
             1'b1, 1'b0, 1'b0, 1'b1, 99, 99, 5, 4, 5, "R6 shared for drive1");
        pair(mk_cfg(1, 1, 0, 0, 3'b001, 3'b000), 4'b1011, mk_cfg(1, 1, 0, 0, 3'b001, 3'b000), 4'b1011,
             1'b1, 1'b1, 1'b0, 1'b1, 99, 99, 3, 1, 3, "R6 slave for drive1");
        pair(mk_cfg(1, 1, 1, 2, 3'b001, 3'b001), 4'b1011, mk_cfg(1, 1, 1, 2, 3'b001, 3'b001), 4'b1011,
             1'b0, 1'b0, 1'b0, 1'b1, 99, 99, 4, 2, 4, "R6 shared for drive0");

        // R7: DMA-only on drive 1
        pair(mk_cfg(1, 0, 2, 3, 3'b101, 3'b000), 4'h0, mk_cfg(1, 0, 2, 3, 3'b101, 3'b000), 4'h0,
             1'b1, 1'b0, 1'b0, 1'b1, 99, 99, 12, 10, 12, "R7 PIO compatible");
        pair(mk_cfg(1, 0, 2, 3, 3'b101, 3'b000), 4'h0, mk_cfg(1, 0, 2, 3, 3'b101, 3'b000), 4'h0,
             1'b1, 1'b1, 1'b1, 1'b1, 99, 99, 3, 1, 3, "R7 DMA fast");
        pair(mk_cfg(1, 0, 1, 1, 3'b101, 3'b000), 4'h0, mk_cfg(1, 0, 1, 1, 3'b101, 3'b000), 4'h0,
             1'b1, 1'b0, 1'b1, 1'b0, 99, 99, 4, 3, 4, "R7 DMA no data-port flag");

        // R8: IORDY waits on drive 0 and drive 1
        for (int k = 0; k < 4; k++) begin
            logic [15:0] c;
            c = mk_cfg(1, 0, 1, 2, 3'b011, 3'b011);
            pair(c, 4'h0, c, 4'h0, 1'(k & 1), 1'b0, 1'b0, 1'b1,
                 4 + k, 4 + 3 - k, 4 + k, 2, 4 + 3 - k, "R8 iordy wait");
        end
        pair(mk_cfg(1, 0, 0, 0, 3'b000, 3'b010), 4'h0, mk_cfg(1, 0, 0, 0, 3'b000, 3'b010), 4'h0,
             1'b0, 1'b1, 1'b0, 1'b0, 15, 12, 15, 10, 12, "R8 iordy on compatible");

        // R9: IORDY disabled on drive 1 while enabled on drive 0
        pair(mk_cfg(1, 0, 2, 3, 3'b001, 3'b011), 4'h0, mk_cfg(1, 0, 2, 3, 3'b001, 3'b011), 4'h0,
             1'b1, 1'b0, 1'b0, 1'b1, 40, 40, 3, 1, 3, "R9 iordy ignored");

        // R11: configuration change during a running cycle
        pair(mk_cfg(1, 0, 2, 3, 3'b000, 3'b001), 4'h0, mk_cfg(1, 0, 0, 0, 3'b000, 3'b000), 4'h0,
             1'b0, 1'b1, 1'b0, 1'b1, 99, 99, 3, 1, 12, "R11 fast to compatible");
        pair(mk_cfg(1, 0, 0, 0, 3'b000, 3'b000), 4'h0, mk_cfg(1, 0, 1, 2, 3'b000, 3'b001), 4'h0,
             1'b0, 1'b0, 1'b0, 1'b1, 99, 99, 12, 10, 4, "R11 compatible to fast");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule